// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a simple memory-mapped master port. It keeps recently used memory lines in a direct-mapped store, so a repeated access costs no memory traffic. It serves byte, halfword and word loads and stores. Stores that hit only update the cached copy and mark the line dirty. A dirty line is copied back to memory only when it is evicted or explicitly flushed.

A request is accepted while `req_ready` is high. The block then finishes it on its own, talking to memory for as many words as the request needs, and signals completion with a one-cycle `rsp_valid` pulse. Accesses flagged as I/O, and any access whose address has bit 31 set, skip the cache and make exactly one memory transfer. Four maintenance operations let software control line state. They differ in two ways: whether they compare the tag or act on the indexed line regardless, and whether they copy a dirty line back or throw its contents away.

Line size (4, 16 or 32 bytes) and total capacity (512 bytes to 64 KB) are parameters. The line index is taken from the address bits just above the line offset, and the remaining upper bits form the tag.

Top module: `dcache_wb`

## Requirements
- R1: A load that hits returns the addressed data, zero-extended. The `req_size` encoding is 0 = byte, 1 = halfword, 2 = word. `req_addr[1:0]` selects the byte lane, and the result appears in `rsp_rdata` low bits. A hit makes no memory transfer.
- R2: A store that hits merges its low `req_wdata` bytes into the cached line at the addressed lanes and marks the line dirty. It makes no memory transfer. The merged data reaches memory on a later eviction or flush.
- R3: A load or store that misses on a clean or invalid line reads the whole new line from memory, word by word in ascending address order from the line base. It writes nothing to memory, and only then completes.
- R4: A load or store that misses on a valid dirty line first writes every word of the old line back to its own address. It then fills the new line as in R3.
- R5: A load or store with `req_io` set, or with `req_addr[31]` set, makes exactly one memory word transfer and leaves the cache contents unchanged. A store uses `mem_byteen` lane enables with the data shifted onto its lanes.
- R6: Flush by index (`req_op` = 2) ignores the tag. It writes the indexed line back if it is valid and dirty, then invalidates it.
- R7: Flush on hit (`req_op` = 3) acts only on a tag hit. It writes the line back if it is dirty, then invalidates it. On a miss it does nothing.
- R8: Initialize by index (`req_op` = 4) invalidates the indexed line and never writes to memory, so dirty data is discarded.
- R9: Initialize on hit (`req_op` = 5) invalidates the line only on a tag hit and never writes to memory.
- R10: While `mem_stall` is high, an active `mem_read` or `mem_write` stays asserted, with its address and write data unchanged. Reads and writes are never requested together.
- R11: Every accepted request produces exactly one `rsp_valid` pulse of one cycle. `req_ready` is low from acceptance until the cycle after that pulse. Load is `req_op` = 0 and store is `req_op` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 3 | 0 load, 1 store, 2 flush index, 3 flush hit, 4 init index, 5 init hit |
| req_io | input | 1 | Force uncached access for load/store |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Request complete (one cycle) |
| rsp_rdata | output | 32 | Load result, zero-extended |
| mem_read | output | 1 | Memory read request |
| mem_write | output | 1 | Memory write request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_byteen | output | 4 | Byte lane enables |
| mem_rdata | input | 32 | Read data, valid in the non-stalled cycle |
| mem_stall | input | 1 | Memory not ready; hold the request |

## Verification
A corrupted dirty bit appears only later. If the bit is lost, a store's data never reaches memory on eviction. If a bit is set in error, the next miss on that index makes a whole line of write transfers that should not happen. The bench therefore counts memory writes and reads per request and compares the complete memory image against an independent model. A wrong tag or valid bit shows at once, as a miss where a hit was due (or the reverse), in that request's transfer counts and returned load data. An error in the lane steering shows on the very response it affects.

// File: rtl/dcache_pkg.sv
// Shared encodings for the write-back data cache.
// Assumes: request operation codes are fixed by the processor side.
package dcache_pkg;
    typedef enum logic [2:0] {
        OP_LOAD      = 3'd0,
        OP_STORE     = 3'd1,
        OP_FLUSH_IDX = 3'd2,
        OP_FLUSH_HIT = 3'd3,
        OP_INIT_IDX  = 3'd4,
        OP_INIT_HIT  = 3'd5
    } cache_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DECIDE, ST_WBACK, ST_FILL, ST_UNCACHED, ST_DONE
    } ctl_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/dcache_tagstore.sv
// Per-line valid, dirty and tag state for a direct-mapped cache.
// Assumes: one line is addressed per cycle; fill has priority over
// invalidate, which has priority over setting the dirty bit.
module dcache_tagstore #(
    parameter int LINES = 32,
    parameter int TAG_W = 23,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inval_en,
    input  logic             dirty_en,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid and dirty bits: cleared by reset, updated by fill/inval/store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (inval_en) begin
            valid_q[idx] <= 1'b0;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_en) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag array: written only when a line fill completes.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
endmodule

// File: rtl/dcache_datastore.sv
// Line data array, one 32-bit word per entry, byte-enabled write.
// Assumes: asynchronous read, single write port.
module dcache_datastore #(
    parameter int LINES = 32,
    parameter int WPL   = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = (WPL > 1) ? $clog2(WPL) : 1,
    localparam int AW     = $clog2(LINES * WPL)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] wsel,
    input  logic              we,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    logic [31:0] mem_q [LINES * WPL];
    logic [AW-1:0] word_a;

    assign word_a = AW'(idx) * AW'(WPL) + AW'(wsel);

    // Byte-lane write of the addressed word.
    always_ff @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (we && be[b]) mem_q[word_a][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    assign rdata = mem_q[word_a];
endmodule

// File: rtl/dcache_lanes.sv
// Byte-lane steering: store enables/data placement and load extraction.
// Assumes: accesses are naturally aligned to their size.
module dcache_lanes
    import dcache_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  off,
    input  logic [31:0] st_data,
    input  logic [31:0] ld_word,
    output logic [3:0]  be,
    output logic [31:0] st_lanes,
    output logic [31:0] ld_data
);
    logic [31:0] shifted;

    // Lane enables and zero-extended load result per access size.
    always_comb begin
        shifted  = ld_word >> {off, 3'b000};
        st_lanes = st_data << {off, 3'b000};
        case (size)
            SZ_BYTE: begin
                be      = 4'b0001 << off;
                ld_data = {24'b0, shifted[7:0]};
            end
            SZ_HALF: begin
                be      = 4'b0011 << off;
                ld_data = {16'b0, shifted[15:0]};
            end
            default: begin
                be      = 4'hF;
                ld_data = ld_word;
            end
        endcase
    end
endmodule

// File: rtl/dcache_wb.sv
// Direct-mapped write-back data cache with uncached path and four
// maintenance operations. One request in flight; memory port transfers
// complete in any cycle where a request is up and mem_stall is low, with
// read data valid in that same cycle.
module dcache_wb
    import dcache_pkg::*;
#(
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_op,
    input  logic        req_io,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mem_read,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_byteen,
    input  logic [31:0] mem_rdata,
    input  logic        mem_stall
);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int WPL    = LINE_BYTES / 4;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = 32 - OFF_W - IDX_W;
    localparam int WSEL_W = (WPL > 1) ? $clog2(WPL) : 1;

    ctl_state_e        state;
    cache_op_e         op_q;
    logic [31:0]       addr_q, wdata_q, unc_q;
    logic [1:0]        size_q;
    logic              byp_q, inval_q;
    logic [WSEL_W-1:0] cnt;

    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q, t_tag;
    logic [WSEL_W-1:0] wsel_q, ds_wsel;
    logic              t_valid, t_dirty, hit, last, xfer, is_access, cached_store;
    logic [3:0]        lane_be, ds_be;
    logic [31:0]       st_lanes, ld_data, ds_rdata, ds_wdata, line_tag_sel;
    logic              ds_we;
    logic              idle_w;

    assign idx_q     = IDX_W'(addr_q >> OFF_W);
    assign tag_q     = TAG_W'(addr_q >> (OFF_W + IDX_W));
    assign wsel_q    = WSEL_W'((addr_q >> 2) & 32'(WPL - 1));
    assign hit       = t_valid && (t_tag == tag_q);
    assign last      = (cnt == WSEL_W'(WPL - 1));
    assign is_access = (op_q == OP_LOAD) || (op_q == OP_STORE);
    assign cached_store = (state == ST_DONE) && (op_q == OP_STORE) && !byp_q;
    assign idle_w    = (state == ST_IDLE);

    // Memory port request, address and data per controller state.
    always_comb begin
        mem_read     = (state == ST_FILL) || (state == ST_UNCACHED && op_q == OP_LOAD);
        mem_write    = (state == ST_WBACK) || (state == ST_UNCACHED && op_q == OP_STORE);
        line_tag_sel = (state == ST_WBACK) ? 32'(t_tag) : 32'(tag_q);
        if (state == ST_UNCACHED) begin
            mem_addr   = {addr_q[31:2], 2'b00};
            mem_wdata  = st_lanes;
            mem_byteen = lane_be;
        end else begin
            mem_addr   = (line_tag_sel << (OFF_W + IDX_W)) | (32'(idx_q) << OFF_W)
                       | (32'(cnt) << 2);
            mem_wdata  = ds_rdata;
            mem_byteen = 4'hF;
        end
    end
    assign xfer = (mem_read || mem_write) && !mem_stall;

    // Data array port selection: line fill or store merge.
    always_comb begin
        ds_wsel  = (state == ST_WBACK || state == ST_FILL) ? cnt : wsel_q;
        ds_we    = (state == ST_FILL && xfer) || cached_store;
        ds_be    = (state == ST_FILL) ? 4'hF : lane_be;
        ds_wdata = (state == ST_FILL) ? mem_rdata : st_lanes;
    end

    // Request sequencing: decide, write back, fill, uncached, complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_LOAD;
            addr_q  <= '0;
            wdata_q <= '0;
            size_q  <= '0;
            byp_q   <= 1'b0;
            inval_q <= 1'b0;
            cnt     <= '0;
            unc_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    op_q    <= cache_op_e'(req_op);
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    size_q  <= req_size;
                    byp_q   <= (req_io || req_addr[31]) && (req_op <= 3'd1);
                    state   <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    cnt <= '0;
                    if (byp_q) state <= ST_UNCACHED;
                    else begin
                        case (op_q)
                            OP_LOAD, OP_STORE:
                                state <= hit ? ST_DONE : ((t_valid && t_dirty) ? ST_WBACK : ST_FILL);
                            OP_FLUSH_IDX: begin
                                inval_q <= 1'b1;
                                state   <= (t_valid && t_dirty) ? ST_WBACK : ST_DONE;
                            end
                            OP_FLUSH_HIT: begin
                                inval_q <= hit;
                                state   <= (hit && t_dirty) ? ST_WBACK : ST_DONE;
                            end
                            OP_INIT_IDX: begin
                                inval_q <= 1'b1;
                                state   <= ST_DONE;
                            end
                            OP_INIT_HIT: begin
                                inval_q <= hit;
                                state   <= ST_DONE;
                            end
                            default: state <= ST_DONE;
                        endcase
                    end
                end
                ST_WBACK: if (xfer) begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) state <= is_access ? ST_FILL : ST_DONE;
                end
                ST_FILL: if (xfer) begin
                    cnt <= last ? '0 : cnt + 1'b1;
                    if (last) state <= ST_DONE;
                end
                ST_UNCACHED: if (xfer) begin
                    unc_q <= mem_rdata;
                    state <= ST_DONE;
                end
                default: begin
                    inval_q <= 1'b0;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

    dcache_tagstore #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx_q),
        .fill_en    (state == ST_FILL && xfer && last),
        .fill_tag   (tag_q),
        .inval_en   (state == ST_DONE && inval_q),
        .dirty_en   (cached_store),
        .line_valid (t_valid),
        .line_dirty (t_dirty),
        .line_tag   (t_tag)
    );

    dcache_datastore #(.LINES(LINES), .WPL(WPL)) u_data (
        .clk   (clk),
        .idx   (idx_q),
        .wsel  (ds_wsel),
        .we    (ds_we),
        .be    (ds_be),
        .wdata (ds_wdata),
        .rdata (ds_rdata)
    );

    dcache_lanes u_lanes (
        .size     (size_q),
        .off      (addr_q[1:0]),
        .st_data  (wdata_q),
        .ld_word  (byp_q ? unc_q : ds_rdata),
        .be       (lane_be),
        .st_lanes (st_lanes),
        .ld_data  (ld_data)
    );

    assign req_ready = idle_w;
    assign rsp_valid = (state == ST_DONE);
    assign rsp_rdata = ld_data;
endmodule

// File: rtl/dcache_checker.sv
// Protocol and maintenance-operation properties for dcache_wb.
// Assumes: attached by bind; op_q and st_idle come from the controller.
module dcache_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        mem_read,
    input logic        mem_write,
    input logic        mem_stall,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [2:0]  op_q,
    input logic        st_idle
);
    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write));
    p_hold_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write && mem_stall) |=> (mem_write && $stable(mem_addr) && $stable(mem_wdata)));
    p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_read && mem_stall) |=> (mem_read && $stable(mem_addr)));
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    p_ready_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid);
    p_init_idx_nowb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_idle && op_q == 3'd4) |-> !mem_write);
    p_init_hit_nowb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_idle && op_q == 3'd5) |-> !mem_write);
endmodule

bind dcache_wb dcache_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_read  (mem_read),
    .mem_write (mem_write),
    .mem_stall (mem_stall),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .op_q      (op_q),
    .st_idle   (idle_w)
);

// File: tb/tb_dcache_wb.sv
`timescale 1ns/1ps
module tb_dcache_wb;
    localparam int LB = 16, CB = 512;
    localparam int LINES = CB / LB, WPL = LB / 4, MEMW = 1024;
    localparam logic [2:0] LD = 0, ST = 1, FIDX = 2, FHIT = 3, IIDX = 4, IHIT = 5;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_io = 0, mem_stall = 0;
    logic [2:0] req_op = 0;
    logic [1:0] req_size = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic req_ready, rsp_valid, mem_read, mem_write;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_byteen;

    int errors = 0, checks = 0, nwr = 0, nrd = 0, hold_bad = 0;
    logic [31:0] mem_img [MEMW];
    logic [31:0] ref_img [MEMW];
    bit          ref_v [LINES];
    bit          ref_d [LINES];
    int          ref_tag [LINES];
    logic [31:0] ref_data [LINES][WPL];
    logic        prev_hold = 0;
    logic [31:0] prev_addr = 0;

    always #2 clk = ~clk;

    dcache_wb #(.LINE_BYTES(LB), .CACHE_BYTES(CB)) dut (.*);

    assign mem_rdata = mem_img[mem_addr[11:2]];

    // Memory responder: completes unstalled transfers, tracks hold rule.
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_hold && (!(mem_read || mem_write) || mem_addr != prev_addr)) hold_bad++;
            prev_hold = (mem_read || mem_write) && mem_stall;
            prev_addr = mem_addr;
            if ((mem_read || mem_write) && !mem_stall) begin
                if (mem_write) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_byteen[b]) mem_img[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    nwr++;
                end else nrd++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(logic [31:0] w, logic [1:0] sz, logic [1:0] off);
        logic [31:0] s = w >> (8 * off);
        return sz == 0 ? {24'b0, s[7:0]} : sz == 1 ? {16'b0, s[15:0]} : w;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] w, logic [1:0] sz, logic [1:0] off,
                                          logic [31:0] d);
        logic [31:0] r = w;
        int n = sz == 0 ? 1 : sz == 1 ? 2 : 4;
        for (int b = 0; b < n; b++) r[8*(off+b) +: 8] = d[8*b +: 8];
        return r;
    endfunction

    function automatic int lw(int tg, int idx, int k);
        return (tg * CB + idx * LB + k * 4) / 4;
    endfunction

    task automatic m_wb(input int idx, inout int ew);
        for (int k = 0; k < WPL; k++) ref_img[lw(ref_tag[idx], idx, k)] = ref_data[idx][k];
        ew += WPL;
    endtask

    // Issue one request, predict from the model, compare at the ports.
    task automatic run_op(input logic [2:0] op, input bit io, input logic [31:0] a,
                          input logic [1:0] sz, input logic [31:0] wd);
        int idx = (a / LB) % LINES, tg = (a & 32'h7FFF_FFFF) / CB, w = (a / 4) % WPL;
        int ew = 0, er = 0, n = 0;
        bit byp = (io || a[31]) && op <= ST;
        bit hit = ref_v[idx] && ref_tag[idx] == tg;
        string tag = "R1";
        logic [31:0] exp = 0;
        if (byp) begin
            tag = "R5";
            if (op == LD) begin exp = ext(ref_img[a[11:2]], sz, a[1:0]); er = 1; end
            else begin ref_img[a[11:2]] = merge(ref_img[a[11:2]], sz, a[1:0], wd); ew = 1; end
        end else if (op <= ST) begin
            if (!hit) begin
                tag = (ref_v[idx] && ref_d[idx]) ? "R4" : "R3";
                if (ref_v[idx] && ref_d[idx]) m_wb(idx, ew);
                for (int k = 0; k < WPL; k++) ref_data[idx][k] = ref_img[lw(tg, idx, k)];
                er = WPL; ref_v[idx] = 1; ref_d[idx] = 0; ref_tag[idx] = tg;
            end else if (op == ST) tag = "R2";
            if (op == LD) exp = ext(ref_data[idx][w], sz, a[1:0]);
            else begin ref_data[idx][w] = merge(ref_data[idx][w], sz, a[1:0], wd); ref_d[idx] = 1; end
        end else if (op == FIDX) begin
            tag = "R6";
            if (ref_v[idx] && ref_d[idx]) m_wb(idx, ew);
            ref_v[idx] = 0; ref_d[idx] = 0;
        end else if (op == FHIT) begin
            tag = "R7";
            if (hit && ref_d[idx]) m_wb(idx, ew);
            if (hit) begin ref_v[idx] = 0; ref_d[idx] = 0; end
        end else if (op == IIDX) begin
            tag = "R8"; ref_v[idx] = 0; ref_d[idx] = 0;
        end else begin
            tag = "R9";
            if (hit) begin ref_v[idx] = 0; ref_d[idx] = 0; end
        end
        nwr = 0; nrd = 0;
        req_valid = 1; req_op = op; req_io = io; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
        chk(rsp_valid, "R11", "response seen", 32'(rsp_valid), 1);
        if (op == LD) chk(rsp_rdata == exp, tag, "load data", rsp_rdata, exp);
        chk(nwr == ew, tag, "memory writes", nwr, ew);
        chk(nrd == er, tag, "memory reads", nrd, er);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R11", "single pulse then ready",
            {rsp_valid, req_ready}, 32'b01);
    endtask

    task automatic cmp_img(input string req);
        int bad = 0;
        logic [31:0] a0 = 0, e0 = 0;
        for (int i = 0; i < MEMW; i++)
            if (mem_img[i] !== ref_img[i]) begin
                if (bad == 0) begin a0 = mem_img[i]; e0 = ref_img[i]; end
                bad++;
            end
        chk(bad == 0, req, "memory image", a0, e0);
    endtask

    function automatic logic [31:0] rnd_addr(logic [1:0] sz);
        logic [31:0] a = ($urandom % MEMW) * 4;
        return a + (sz == 0 ? $urandom % 4 : sz == 1 ? ($urandom % 2) * 2 : 0);
    endfunction

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMW; i++) begin
            mem_img[i] = i * 32'h9E37_79B9 + 32'h1234_5678;
            ref_img[i] = mem_img[i];
        end
        for (int i = 0; i < LINES; i++) begin ref_v[i] = 0; ref_d[i] = 0; ref_tag[i] = 0; end
        repeat (5) @(negedge clk);
        chk(req_ready == 1, "R11", "reset ready", 32'(req_ready), 1);
        chk(rsp_valid == 0, "R11", "reset rsp", 32'(rsp_valid), 0);
        chk(!mem_read && !mem_write, "R10", "reset mem idle", {mem_read, mem_write}, 0);
        rst_n = 1;
        fork
            forever begin @(negedge clk); mem_stall = ($urandom % 4) == 0; end
        join_none
        // Directed corner cases.
        run_op(LD, 0, 32'h40, 2, 0);              // R3 clean fill
        run_op(ST, 0, 32'h41, 0, 32'hAB);         // R2 byte store hit
        run_op(LD, 0, 32'h40, 1, 0);              // R1 halfword hit
        run_op(LD, 0, 32'h240, 2, 0);             // R4 dirty eviction
        run_op(LD, 0, 32'h41, 0, 0);              // refill sees stored byte
        run_op(ST, 0, 32'h80, 2, 32'hDEAD_BEEF);
        run_op(IIDX, 0, 32'h80, 2, 0);            // R8 data discarded
        run_op(LD, 0, 32'h80, 2, 0);
        run_op(ST, 0, 32'hC0, 2, 32'h5555_AAAA);
        run_op(IHIT, 0, 32'h2C0, 2, 0);           // R9 miss: no effect
        run_op(FHIT, 0, 32'h2C0, 2, 0);           // R7 miss: no effect
        run_op(FHIT, 0, 32'hC0, 2, 0);            // R7 hit dirty
        run_op(ST, 0, 32'h100, 1, 32'h7777);
        run_op(IHIT, 0, 32'h100, 2, 0);           // R9 hit: dropped
        run_op(LD, 0, 32'h100, 2, 0);
        run_op(ST, 0, 32'h146, 1, 32'hBEEF);
        run_op(FIDX, 0, 32'h346, 2, 0);           // R6 tag ignored
        run_op(ST, 1, 32'h42, 1, 32'hC0DE);       // R5 io store
        run_op(LD, 0, 32'h8000_0040, 2, 0);       // R5 bit-31 load
        cmp_img("R6");
        // Random mix.
        for (int t = 0; t < 1500; t++) begin
            int r = $urandom % 100;
            logic [1:0] sz = 2'($urandom % 3);
            logic [31:0] a = rnd_addr(sz);
            logic [31:0] d = $urandom;
            if (r < 35) run_op(LD, 0, a, sz, 0);
            else if (r < 70) run_op(ST, 0, a, sz, d);
            else if (r < 74) run_op(FIDX, 0, a, 2, 0);
            else if (r < 78) run_op(FHIT, 0, a, 2, 0);
            else if (r < 80) run_op(IIDX, 0, a, 2, 0);
            else if (r < 84) run_op(IHIT, 0, a, 2, 0);
            else begin
                bit io = $urandom % 2;
                run_op((r < 92) ? LD : ST, io, io ? a : (a | 32'h8000_0000), sz, d);
            end
            if (t % 100 == 99) cmp_img("R2");
        end
        for (int i = 0; i < LINES; i++) run_op(FIDX, 0, i * LB, 2, 0);
        cmp_img("R4");
        chk(hold_bad == 0, "R10", "stalled request held", hold_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule